// File: doc/BRIEF.md
# Register Critical-Time Vulnerability Monitor

This block measures how exposed the physical registers of a renamed register file are to an intermittent fault. It follows the current version of every physical register through its life, as signalled by four event strobes, each carrying a register index: allocate, write, read and deallocate. A version holds a live value only between its write and its final read. A stuck-at fault in the register during that span can corrupt a result. Outside that span the fault does no harm.

A fault window arrives as a level (`fault_act`) together with the index of the register it hits. The monitor counts every fault-active cycle. It counts separately the fault-active cycles that land in the critical span of the targeted register. The final read of a version cannot be known when it happens, so each register holds a pending count of hit cycles gathered since its write or its most recent read. That count moves into the overlap counter only when a further read proves the span was still live. Deallocation throws the pending count away. Software divides the two counters to get the vulnerability ratio.

Top module: `reg_crit_monitor`

## Requirements
- R1: Synchronous reset `rst` and the `clr` input both return the block to its initial state: both counters zero, `prot_err` low and every register FREE. `clr` overrides every strobe in the same cycle.
- R2: `fault_cycles` grows by exactly one after every cycle in which `fault_act` is high and `clr` is low.
- R3: Per-register states are FREE (2'b00), ALLOCATED (2'b01), WRITTEN (2'b10) and READ_SEEN (2'b11). When several strobes hit the same index in one cycle, they apply in this priority: deallocate moves any state to FREE; then allocate moves FREE to ALLOCATED; then write moves ALLOCATED to WRITTEN; then read moves WRITTEN or READ_SEEN to READ_SEEN. An allocate of a register that is not FREE is ignored.
- R4: Fault-active cycles that hit a register before its write, including the write cycle itself, are never credited as critical.
- R5: A read of a register in WRITTEN or READ_SEEN adds to `crit_cycles`, one cycle after the read. The amount is the number of fault-active cycles that hit that register after its write or previous read, up to and including the read cycle.
- R6: Hit cycles after the last read, up to deallocation, are discarded. A version that is written and deallocated without any read adds nothing.
- R7: Fault-active cycles aimed at one index are never credited to a read of another index.
- R8: A read of a register in FREE or ALLOCATED leaves `crit_cycles` unchanged.
- R9: A write to a register that is not ALLOCATED (unallocated, or a second write to the same version) sets `prot_err` one cycle later. The flag stays high until reset or `clr`.
- R10: `crit_cycles` never exceeds `fault_cycles`. `crit_cycles` changes only after a cycle that carries a read strobe or `clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of counters, flag and register states |
| alloc_vld | input | 1 | Allocate strobe |
| alloc_idx | input | IDX_W | Register index for allocate |
| wr_vld | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Register index for write |
| rd_vld | input | 1 | Read strobe |
| rd_idx | input | IDX_W | Register index for read |
| dealloc_vld | input | 1 | Deallocate strobe |
| dealloc_idx | input | IDX_W | Register index for deallocate |
| fault_act | input | 1 | Fault window active in this cycle |
| fault_idx | input | IDX_W | Register the fault window targets |
| crit_cycles | output | CNT_W | Fault-active cycles that overlapped critical time |
| fault_cycles | output | CNT_W | Total fault-active cycles |
| prot_err | output | 1 | Sticky protocol-error flag |

## Verification
The bench places fault cycles on the write cycle, on the read cycle and just after the last read. A design that treats the window as open at the write, closed before the read, or open through to deallocation would show a `crit_cycles` that is off by those cycles. It deallocates a written version that was never read, and it reads registers that are FREE or only ALLOCATED. A design that credits eagerly, or credits from the wrong state, would add cycles there. It aims faults at one register while reading another, which catches a slot mix-up. It also checks that the protocol flag rises on an unallocated write and on a repeated write, and stays high until clear. A long random phase with occasional clears compares every cycle against a model that records fault hits by cycle number.

// File: rtl/rcvm_pkg.sv
package rcvm_pkg;

    // Lifecycle of one register version
    typedef enum logic [1:0] {
        ST_FREE    = 2'b00,
        ST_ALLOC   = 2'b01,
        ST_WRITTEN = 2'b10,
        ST_READ    = 2'b11
    } slot_state_e;

    // Events that concern one slot in one cycle
    typedef struct packed {
        logic alloc;
        logic wr;
        logic rd;
        logic dealloc;
        logic fault;
    } slot_ev_t;

    // True while the held value is live (between write and last read)
    function automatic logic in_window(slot_state_e s);
        return (s == ST_WRITTEN) || (s == ST_READ);
    endfunction

    function automatic int idx_bits(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rcvm_slot.sv
module rcvm_slot
    import rcvm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  slot_ev_t         ev_i,
    output logic             credit_vld_o,
    output logic [CNT_W-1:0] credit_o,
    output logic             wr_bad_o
);

    slot_state_e      state_q;
    logic [CNT_W-1:0] pend_q;
    logic             live;

    assign live         = in_window(state_q);
    assign credit_vld_o = ev_i.rd && live;
    assign credit_o     = pend_q + CNT_W'(ev_i.fault);
    assign wr_bad_o     = ev_i.wr && (state_q != ST_ALLOC);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state_q <= ST_FREE;
            pend_q  <= '0;
        end else if (ev_i.dealloc) begin
            state_q <= ST_FREE;
            pend_q  <= '0;
        end else if (ev_i.alloc && state_q == ST_FREE) begin
            state_q <= ST_ALLOC;
            pend_q  <= '0;
        end else if (ev_i.wr && state_q == ST_ALLOC) begin
            state_q <= ST_WRITTEN;
            pend_q  <= '0;
        end else if (ev_i.rd && live) begin
            // pending plus this cycle's hit handed over as credit
            state_q <= ST_READ;
            pend_q  <= '0;
        end else if (ev_i.fault && live) begin
            pend_q  <= pend_q + 1'b1;
        end
    end

endmodule

// File: rtl/rcvm_accum.sv
module rcvm_accum #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add_vld,
    input  logic [CNT_W-1:0] add_val,
    input  logic             fault_act,
    input  logic             err_set,
    output logic [CNT_W-1:0] crit_cnt,
    output logic [CNT_W-1:0] fault_cnt,
    output logic             err
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crit_cnt  <= '0;
            fault_cnt <= '0;
            err       <= 1'b0;
        end else begin
            if (add_vld)   crit_cnt  <= crit_cnt + add_val;
            if (fault_act) fault_cnt <= fault_cnt + 1'b1;
            if (err_set)   err       <= 1'b1;
        end
    end

endmodule

// File: rtl/reg_crit_monitor.sv
module reg_crit_monitor
    import rcvm_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int CNT_W    = 32,
    parameter int IDX_W    = idx_bits(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             alloc_vld,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             wr_vld,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             rd_vld,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             dealloc_vld,
    input  logic [IDX_W-1:0] dealloc_idx,
    input  logic             fault_act,
    input  logic [IDX_W-1:0] fault_idx,
    output logic [CNT_W-1:0] crit_cycles,
    output logic [CNT_W-1:0] fault_cycles,
    output logic             prot_err
);

    slot_ev_t            ev    [NUM_REGS];
    logic [CNT_W-1:0]    cval  [NUM_REGS];
    logic [NUM_REGS-1:0] cvld;
    logic [NUM_REGS-1:0] wbad;
    logic [CNT_W-1:0]    add_val;
    logic                add_vld;
    logic                err_set;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

        assign ev[g] = '{alloc:   alloc_vld   && (alloc_idx   == MY_IDX),
                         wr:      wr_vld      && (wr_idx      == MY_IDX),
                         rd:      rd_vld      && (rd_idx      == MY_IDX),
                         dealloc: dealloc_vld && (dealloc_idx == MY_IDX),
                         fault:   fault_act   && (fault_idx   == MY_IDX)};

        rcvm_slot #(.CNT_W(CNT_W)) u_slot (
            .clk          (clk),
            .rst          (rst),
            .clr          (clr),
            .ev_i         (ev[g]),
            .credit_vld_o (cvld[g]),
            .credit_o     (cval[g]),
            .wr_bad_o     (wbad[g])
        );
    end

    // At most one slot sees the read strobe, so an OR-merge selects it
    always_comb begin
        add_val = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            add_val = add_val | (cval[k] & {CNT_W{cvld[k]}});
        end
        add_vld = |cvld;
        err_set = |wbad;
    end

    rcvm_accum #(.CNT_W(CNT_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .add_vld   (add_vld),
        .add_val   (add_val),
        .fault_act (fault_act),
        .err_set   (err_set),
        .crit_cnt  (crit_cycles),
        .fault_cnt (fault_cycles),
        .err       (prot_err)
    );

endmodule

// File: rtl/rcvm_chk.sv
module rcvm_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             rd_vld,
    input logic             wr_vld,
    input logic             fault_act,
    input logic [CNT_W-1:0] crit_cycles,
    input logic [CNT_W-1:0] fault_cycles,
    input logic             prot_err
);

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crit_cycles == '0 && fault_cycles == '0 && !prot_err));

    assert_fault_count_R2: assert property (@(posedge clk) disable iff (rst)
        !clr |=> fault_cycles == $past(fault_cycles) + CNT_W'($past(fault_act)));

    assert_no_credit_without_read_R10: assert property (@(posedge clk) disable iff (rst)
        (!clr && !rd_vld) |=> $stable(crit_cycles));

    assert_crit_within_total_R10: assert property (@(posedge clk) disable iff (rst)
        crit_cycles <= fault_cycles);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (prot_err && !clr) |=> prot_err);

    assert_err_needs_write_R9: assert property (@(posedge clk) disable iff (rst)
        (!prot_err && !wr_vld && !clr) |=> !prot_err);

endmodule

bind reg_crit_monitor rcvm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clr          (clr),
    .rd_vld       (rd_vld),
    .wr_vld       (wr_vld),
    .fault_act    (fault_act),
    .crit_cycles  (crit_cycles),
    .fault_cycles (fault_cycles),
    .prot_err     (prot_err)
);

// File: tb/sim_reg_crit_monitor.sv
`timescale 1ns/1ps
module sim_reg_crit_monitor;

    localparam int  NR  = 8;
    localparam int  CW  = 32;
    localparam int  IW  = 3;
    localparam time PER = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, clr;
    logic          alloc_vld, wr_vld, rd_vld, dealloc_vld, fault_act;
    logic [IW-1:0] alloc_idx, wr_idx, rd_idx, dealloc_idx, fault_idx;
    logic [CW-1:0] crit_cycles, fault_cycles;
    logic          prot_err;

    reg_crit_monitor #(.NUM_REGS(NR), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .clr(clr),
        .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
        .wr_vld(wr_vld), .wr_idx(wr_idx),
        .rd_vld(rd_vld), .rd_idx(rd_idx),
        .dealloc_vld(dealloc_vld), .dealloc_idx(dealloc_idx),
        .fault_act(fault_act), .fault_idx(fault_idx),
        .crit_cycles(crit_cycles), .fault_cycles(fault_cycles),
        .prot_err(prot_err)
    );

    typedef struct {
        logic [CW-1:0] crit;
        logic [CW-1:0] flt;
        logic          err;
        string         tag;
        time           due;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_it;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // Reference model: 0 free, 1 allocated, 2 written, 3 read seen
    int            mst  [NR];
    int            mark [NR];
    int            ftgt [8192];
    int            cyc = 0;
    logic [CW-1:0] ecrit = '0;
    logic [CW-1:0] efault = '0;
    bit            eerr = 1'b0;

    // Drive one cycle of events (-1 means none), update model, queue expectation
    task automatic cyc_ev(int al, int wr, int rd, int de, int fi, bit c, string tag);
        exp_t it;
        int   sum;
        alloc_vld   = (al >= 0); alloc_idx   = IW'((al < 0) ? 0 : al);
        wr_vld      = (wr >= 0); wr_idx      = IW'((wr < 0) ? 0 : wr);
        rd_vld      = (rd >= 0); rd_idx      = IW'((rd < 0) ? 0 : rd);
        dealloc_vld = (de >= 0); dealloc_idx = IW'((de < 0) ? 0 : de);
        fault_act   = (fi >= 0); fault_idx   = IW'((fi < 0) ? 0 : fi);
        clr         = c;
        if (c) begin
            for (int r = 0; r < NR; r++) mst[r] = 0;
            ecrit = '0; efault = '0; eerr = 1'b0;
            ftgt[cyc] = -1;
        end else begin
            ftgt[cyc] = fi;
            if (rd >= 0 && mst[rd] >= 2) begin
                sum = 0;
                for (int k = mark[rd] + 1; k <= cyc; k++)
                    if (ftgt[k] == rd) sum++;
                ecrit = ecrit + CW'(sum);
                mark[rd] = cyc;
            end
            if (fi >= 0) efault = efault + 1;
            if (wr >= 0 && mst[wr] != 1) eerr = 1'b1;
            for (int r = 0; r < NR; r++) begin
                if (de == r)                      mst[r] = 0;
                else if (al == r && mst[r] == 0)  mst[r] = 1;
                else if (wr == r && mst[r] == 1) begin mst[r] = 2; mark[r] = cyc; end
                else if (rd == r && mst[r] >= 2)  mst[r] = 3;
            end
        end
        cyc++;
        it.crit = ecrit; it.flt = efault; it.err = eerr;
        it.tag = tag; it.due = $time + PER;
        sbq.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compare outputs one cycle after each driven cycle
    always @(negedge clk) begin
        if (sbq.size() > 0 && sbq[0].due <= $time) begin
            mon_it = sbq.pop_front();
            checks++;
            if (crit_cycles !== mon_it.crit || fault_cycles !== mon_it.flt || prot_err !== mon_it.err) begin
                errors++;
                $display("FAIL %s: crit=%0d exp %0d, total=%0d exp %0d, err=%0b exp %0b",
                         mon_it.tag, crit_cycles, mon_it.crit, fault_cycles, mon_it.flt,
                         prot_err, mon_it.err);
            end
        end
    end

    initial begin
        #(PER * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung, expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int al, wr, rd, de, fi;
        bit c;
        rst = 1'b1; clr = 1'b0;
        alloc_vld = 0; wr_vld = 0; rd_vld = 0; dealloc_vld = 0; fault_act = 0;
        alloc_idx = '0; wr_idx = '0; rd_idx = '0; dealloc_idx = '0; fault_idx = '0;
        for (int r = 0; r < NR; r++) begin mst[r] = 0; mark[r] = 0; end
        for (int k = 0; k < 8192; k++) ftgt[k] = -1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        checks++;
        if (crit_cycles !== '0 || fault_cycles !== '0 || prot_err !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: crit=%0d total=%0d err=%0b, expected 0 0 0",
                     crit_cycles, fault_cycles, prot_err);
        end

        // Full lifecycle of register 1
        cyc_ev( 1, -1, -1, -1, -1, 0, "R3 alloc");
        cyc_ev(-1, -1, -1, -1,  1, 0, "R4 fault before write");
        cyc_ev(-1, -1, -1, -1,  1, 0, "R2 fault count");
        cyc_ev(-1,  1, -1, -1,  1, 0, "R4 fault on write cycle");
        cyc_ev(-1, -1, -1, -1,  1, 0, "R5 pending");
        cyc_ev(-1, -1, -1, -1, -1, 0, "R5 pending idle");
        cyc_ev(-1, -1, -1, -1,  1, 0, "R5 pending");
        cyc_ev(-1, -1,  1, -1,  1, 0, "R5 first read credit");
        cyc_ev(-1, -1, -1, -1,  1, 0, "R5 pending again");
        cyc_ev(-1, -1,  1, -1, -1, 0, "R5 second read credit");
        cyc_ev(-1, -1, -1, -1,  1, 0, "R6 after last read");
        cyc_ev(-1, -1, -1, -1,  1, 0, "R6 after last read");
        cyc_ev(-1, -1, -1,  1,  1, 0, "R6 dealloc discards");
        cyc_ev(-1, -1, -1, -1, -1, 0, "R6 idle");

        // Written but never read
        cyc_ev( 2, -1, -1, -1, -1, 0, "R3 alloc");
        cyc_ev(-1,  2, -1, -1, -1, 0, "R3 write");
        cyc_ev(-1, -1, -1, -1,  2, 0, "R6 unread");
        cyc_ev(-1, -1, -1, -1,  2, 0, "R6 unread");
        cyc_ev(-1, -1, -1,  2, -1, 0, "R6 dealloc unread");
        cyc_ev(-1, -1,  2, -1,  2, 0, "R8 read after dealloc");

        // Faults aimed elsewhere
        cyc_ev( 3, -1, -1, -1, -1, 0, "R3 alloc");
        cyc_ev(-1,  3, -1, -1, -1, 0, "R3 write");
        cyc_ev(-1, -1, -1, -1,  5, 0, "R7 other target");
        cyc_ev(-1, -1, -1, -1,  5, 0, "R7 other target");
        cyc_ev(-1, -1,  3, -1,  5, 0, "R7 read sees none");

        // Reads of non-live registers
        cyc_ev(-1, -1,  4, -1,  4, 0, "R8 read free");
        cyc_ev( 4, -1, -1, -1, -1, 0, "R3 alloc");
        cyc_ev(-1, -1,  4, -1,  4, 0, "R8 read allocated");

        // Protocol errors
        cyc_ev(-1,  5, -1, -1, -1, 0, "R9 write unallocated");
        cyc_ev(-1, -1, -1, -1, -1, 0, "R9 sticky");
        cyc_ev(-1, -1, -1, -1,  0, 0, "R9 sticky");
        cyc_ev(-1, -1, -1, -1, -1, 1, "R1 clear");
        cyc_ev( 6, -1, -1, -1, -1, 0, "R3 alloc");
        cyc_ev(-1,  6, -1, -1, -1, 0, "R3 write");
        cyc_ev(-1,  6, -1, -1, -1, 0, "R9 double write");
        cyc_ev(-1, -1, -1, -1,  6, 1, "R1 clear overrides fault");

        // Precedence on one index
        cyc_ev( 0, -1, -1,  0, -1, 0, "R3 dealloc beats alloc");
        cyc_ev(-1,  0, -1, -1, -1, 0, "R3 write after no alloc");
        cyc_ev(-1, -1, -1, -1, -1, 1, "R1 clear");
        cyc_ev( 7, -1, -1, -1, -1, 0, "R3 alloc");
        cyc_ev( 7, -1, -1, -1,  7, 0, "R3 realloc ignored");
        cyc_ev(-1,  7, -1, -1, -1, 0, "R3 write");
        cyc_ev(-1, -1, -1, -1,  7, 0, "R5 pending");
        cyc_ev(-1, -1,  7,  7,  7, 0, "R3 read with dealloc");
        cyc_ev(-1, -1,  7, -1,  7, 0, "R8 read after dealloc");

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            al = ($urandom % 3 == 0) ? int'($urandom % NR) : -1;
            wr = ($urandom % 3 == 0) ? int'($urandom % NR) : -1;
            rd = ($urandom % 2 == 0) ? int'($urandom % NR) : -1;
            de = ($urandom % 5 == 0) ? int'($urandom % NR) : -1;
            fi = ($urandom % 2 == 0) ? int'($urandom % NR) : -1;
            c  = ($urandom % 400 == 0);
            cyc_ev(al, wr, rd, de, fi, c, "R10 random");
        end

        cyc_ev(-1, -1, -1, -1, -1, 0, "R10 drain");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule